// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address for one access at a time. Each access is a read, a write or an instruction fetch, made at user or privileged level. When the MMU is enabled and the access is not taken by the bypass rule, the walker fetches a first-level descriptor from memory. That descriptor either maps a 4 MB superpage or points to a second-level table, whose entry maps a 4 KB page. The walker returns the physical address, a large-page flag and the read/write/execute grants. On a failure it returns a fault code instead, and it reports the failure as an instruction abort or a data abort.

Table reads leave through a single request/acknowledge port with at most one read outstanding. A caller presents a request while the walker is idle and waits for the one-cycle completion pulse. Two conditions complete without touching memory. The first is a disabled MMU. The second is a privileged access whose address has its top bit clear. Failures are recorded in a fault-status register and a fault-address register, and both keep their values until the next fault.

Top module: `xw_walker`

## Requirements
- R1: After reset, busy, done, mem_req, fault_status and fault_addr are all zero.
- R2: With mmu_on low at acceptance, the result is pa = va with read, write and execute all granted and big_page = 0. No memory read is issued, and done rises in the cycle after acceptance.
- R3: With mmu_on high, a privileged access (req_user = 0) whose va[31] = 0 issues no read. It completes in the cycle after acceptance with pa = va with bit 31 set and all three grants set. A user access, or any access with va[31] = 1, is walked.
- R4: The first read goes to {tbl_base[31:12], va[31:22], 2'b00}. A descriptor with bits [1:0] = 3 and present bit 2 set gives pa = {desc[31:22], va[21:0]} and big_page = 1.
- R5: A first-level descriptor with bits [1:0] = 0 and bit 2 set causes a second read at {desc[31:12], va[21:12], 2'b00}. If that entry has bit 2 set and bits [1:0] = 0, the result is pa = {entry[31:12], va[11:0]} with big_page = 0.
- R6: A missing bit 2 gives fault code 0x0B in a superpage descriptor, 0x05 in a table pointer and 0x08 in a second-level entry.
- R7: A first-level type of 1 or 2, or a present second-level entry of non-zero type, ends the walk with illegal high and fault low. fault_status and fault_addr are left unchanged.
- R8: The grants are bit 8 (read), bit 7 (write) and bit 6 (execute) of the final descriptor. For user accesses, where req_acc is 0 = read, 1 = write and 2 = execute, a missing grant faults with 0x11, 0x12 or 0x13. Privileged accesses never take a permission fault.
- R9: On a fault, fault_status takes the code and fault_addr takes the va, both in the done cycle. iabort is high for execute accesses and dabort for reads and writes, exactly one of the two. Both registers hold when no fault occurs.
- R10: mem_req stays high with a stable mem_addr until mem_ack. busy is high exactly while a read is pending. done is a one-cycle pulse in a cycle where busy is low, one cycle after the final acknowledge.
- R11: Requests are taken only while busy is low, including the cycle of a done pulse. req_va, req_acc, req_user, mmu_on and tbl_base are sampled at acceptance. Requests presented while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_va | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_user | input | 1 | User-level access when high |
| mmu_on | input | 1 | Translation enable |
| tbl_base | input | 32 | First-level table base (bits 31:12 used) |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 32 | Table read address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 32 | Descriptor read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Completion pulse |
| pa | output | 32 | Physical address |
| big_page | output | 1 | Result maps a 4 MB superpage |
| grant_rd | output | 1 | Read permitted |
| grant_wr | output | 1 | Write permitted |
| grant_ex | output | 1 | Execute permitted |
| fault | output | 1 | Translation fault, with done |
| illegal | output | 1 | Illegal descriptor, with done |
| iabort | output | 1 | Fault was an instruction abort |
| dabort | output | 1 | Fault was a data abort |
| fault_status | output | 5 | Code of the last fault |
| fault_addr | output | 32 | Virtual address of the last fault |

## Verification
The case that needs care is the completion pulse of one translation landing in the same cycle that the next request is accepted. This happens after any walk, and it also happens on every cycle of a run of back-to-back bypass translations. The bench drives req_valid most of the time, so requests are waiting when each walk ends. A behavioural model then predicts, cycle by cycle, which of those requests is taken and which are ignored. Memory latency varies from zero to two idle cycles per read, which moves the done cycle against the changing request inputs. busy, done, mem_req, mem_addr and the fault registers are compared on every cycle, so an extra accept or a dropped accept is caught.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int CODE_W      = 5;
    localparam int PG_BITS     = 12;
    localparam int SP_BITS     = 22;
    localparam int BIT_PRESENT = 2;
    localparam int BIT_RD      = 8;
    localparam int BIT_WR      = 7;
    localparam int BIT_EX      = 6;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        DT_TABLE = 2'd0,
        DT_BAD1  = 2'd1,
        DT_BAD2  = 2'd2,
        DT_SUPER = 2'd3
    } dtype_e;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_LVL1 = 2'd1,
        WS_LVL2 = 2'd2
    } wstate_e;

    localparam logic [CODE_W-1:0] FC_SUPER_MISS = 5'h0B;
    localparam logic [CODE_W-1:0] FC_TABLE_MISS = 5'h05;
    localparam logic [CODE_W-1:0] FC_PAGE_MISS  = 5'h08;
    localparam logic [CODE_W-1:0] FC_NO_RD      = 5'h11;
    localparam logic [CODE_W-1:0] FC_NO_WR      = 5'h12;
    localparam logic [CODE_W-1:0] FC_NO_EX      = 5'h13;
endpackage

// File: rtl/xw_bypass.sv
module xw_bypass #(
    parameter int AW = 32
) (
    input  logic          mmu_on,
    input  logic          user,
    input  logic [AW-1:0] va,
    output logic          take,
    output logic [AW-1:0] pa
);
    localparam logic [AW-1:0] TOP_BIT = {1'b1, {(AW-1){1'b0}}};

    always_comb begin
        take = !mmu_on || (!user && !va[AW-1]);
        pa   = mmu_on ? (va | TOP_BIT) : va;
    end
endmodule

// File: rtl/xw_addr_gen.sv
module xw_addr_gen
    import xw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-PG_BITS-1:0] base_hi,
    input  logic [AW-SP_BITS-1:0] new_va_hi,
    input  logic [AW-1:0]         cur_va,
    input  logic [AW-PG_BITS-1:0] desc_hi,
    output logic [AW-1:0]         l1_addr,
    output logic [AW-1:0]         l2_addr,
    output logic [AW-1:0]         sp_pa,
    output logic [AW-1:0]         pg_pa
);
    localparam int SP_HI_W = AW - SP_BITS;

    always_comb begin
        l1_addr = {base_hi, new_va_hi, 2'b00};
        l2_addr = {desc_hi, cur_va[SP_BITS-1:PG_BITS], 2'b00};
        sp_pa   = {desc_hi[AW-PG_BITS-1 -: SP_HI_W], cur_va[SP_BITS-1:0]};
        pg_pa   = {desc_hi, cur_va[PG_BITS-1:0]};
    end
endmodule

// File: rtl/xw_perm_chk.sv
module xw_perm_chk
    import xw_pkg::*;
(
    input  logic [2:0]        rwx,
    input  logic [1:0]        acc,
    input  logic              user,
    output logic              deny,
    output logic [CODE_W-1:0] code
);
    always_comb begin
        deny = 1'b0;
        code = '0;
        if (user) begin
            unique case (acc_e'(acc))
                ACC_WRITE: begin deny = !rwx[1]; code = FC_NO_WR; end
                ACC_EXEC:  begin deny = !rwx[0]; code = FC_NO_EX; end
                default:   begin deny = !rwx[2]; code = FC_NO_RD; end
            endcase
        end
    end
endmodule

// File: rtl/xw_walker.sv
module xw_walker
    import xw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_va,
    input  logic [1:0]        req_acc,
    input  logic              req_user,
    input  logic              mmu_on,
    input  logic [AW-1:0]     tbl_base,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_ack,
    input  logic [AW-1:0]     mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [AW-1:0]     pa,
    output logic              big_page,
    output logic              grant_rd,
    output logic              grant_wr,
    output logic              grant_ex,
    output logic              fault,
    output logic              illegal,
    output logic              iabort,
    output logic              dabort,
    output logic [CODE_W-1:0] fault_status,
    output logic [AW-1:0]     fault_addr
);
    typedef struct packed {
        wstate_e            st;
        logic [AW-1:0]      va;
        logic [1:0]         acc;
        logic               user;
        logic               mem_req;
        logic [AW-1:0]      mem_addr;
        logic               done;
        logic [AW-1:0]      pa;
        logic               big;
        logic [2:0]         rwx;
        logic               fault;
        logic               illegal;
        logic               iab;
        logic               dab;
        logic [CODE_W-1:0]  fsr;
        logic [AW-1:0]      far;
    } regs_t;

    regs_t r_q, r_d;

    logic          byp_take;
    logic [AW-1:0] byp_pa;
    logic [AW-1:0] l1_addr, l2_addr, sp_pa, pg_pa;
    logic          perm_deny;
    logic [CODE_W-1:0] perm_code;
    logic          unused_bits;

    assign unused_bits = ^{tbl_base[PG_BITS-1:0],
                           mem_rdata[PG_BITS-1:BIT_RD+1],
                           mem_rdata[BIT_EX-1:BIT_PRESENT+1]};

    xw_bypass #(.AW(AW)) i_bypass (
        .mmu_on (mmu_on),
        .user   (req_user),
        .va     (req_va),
        .take   (byp_take),
        .pa     (byp_pa)
    );

    xw_addr_gen #(.AW(AW)) i_addr (
        .base_hi   (tbl_base[AW-1:PG_BITS]),
        .new_va_hi (req_va[AW-1:SP_BITS]),
        .cur_va    (r_q.va),
        .desc_hi   (mem_rdata[AW-1:PG_BITS]),
        .l1_addr   (l1_addr),
        .l2_addr   (l2_addr),
        .sp_pa     (sp_pa),
        .pg_pa     (pg_pa)
    );

    xw_perm_chk i_perm (
        .rwx  (mem_rdata[BIT_RD:BIT_EX]),
        .acc  (r_q.acc),
        .user (r_q.user),
        .deny (perm_deny),
        .code (perm_code)
    );

    always_comb begin
        logic              end_ok;
        logic              end_flt;
        logic              end_ill;
        logic [CODE_W-1:0] fcode;
        logic [AW-1:0]     ok_pa;
        logic              ok_big;
        logic              present;
        dtype_e            dtype;

        r_d     = r_q;
        r_d.done    = 1'b0;
        r_d.fault   = 1'b0;
        r_d.illegal = 1'b0;
        r_d.iab     = 1'b0;
        r_d.dab     = 1'b0;
        end_ok  = 1'b0;
        end_flt = 1'b0;
        end_ill = 1'b0;
        fcode   = '0;
        ok_pa   = pg_pa;
        ok_big  = 1'b0;
        present = mem_rdata[BIT_PRESENT];
        dtype   = dtype_e'(mem_rdata[1:0]);

        unique case (r_q.st)
            WS_IDLE: begin
                if (req_valid) begin
                    r_d.va   = req_va;
                    r_d.acc  = req_acc;
                    r_d.user = req_user;
                    if (byp_take) begin
                        r_d.done = 1'b1;
                        r_d.pa   = byp_pa;
                        r_d.big  = 1'b0;
                        r_d.rwx  = 3'b111;
                    end else begin
                        r_d.st       = WS_LVL1;
                        r_d.mem_req  = 1'b1;
                        r_d.mem_addr = l1_addr;
                    end
                end
            end
            WS_LVL1: begin
                if (mem_ack) begin
                    unique case (dtype)
                        DT_SUPER: begin
                            if (!present) begin
                                end_flt = 1'b1;
                                fcode   = FC_SUPER_MISS;
                            end else begin
                                end_ok = 1'b1;
                                ok_pa  = sp_pa;
                                ok_big = 1'b1;
                            end
                        end
                        DT_TABLE: begin
                            if (!present) begin
                                end_flt = 1'b1;
                                fcode   = FC_TABLE_MISS;
                            end else begin
                                r_d.st       = WS_LVL2;
                                r_d.mem_addr = l2_addr;
                            end
                        end
                        default: end_ill = 1'b1;
                    endcase
                end
            end
            WS_LVL2: begin
                if (mem_ack) begin
                    if (!present) begin
                        end_flt = 1'b1;
                        fcode   = FC_PAGE_MISS;
                    end else if (dtype != DT_TABLE) begin
                        end_ill = 1'b1;
                    end else begin
                        end_ok = 1'b1;
                        ok_pa  = pg_pa;
                    end
                end
            end
            default: r_d.st = WS_IDLE;
        endcase

        if (end_ok && perm_deny) begin
            end_ok  = 1'b0;
            end_flt = 1'b1;
            fcode   = perm_code;
        end

        if (end_ok || end_flt || end_ill) begin
            r_d.st      = WS_IDLE;
            r_d.mem_req = 1'b0;
            r_d.done    = 1'b1;
        end
        if (end_ok) begin
            r_d.pa  = ok_pa;
            r_d.big = ok_big;
            r_d.rwx = mem_rdata[BIT_RD:BIT_EX];
        end
        if (end_flt) begin
            r_d.fault = 1'b1;
            r_d.fsr   = fcode;
            r_d.far   = r_q.va;
            r_d.iab   = (acc_e'(r_q.acc) == ACC_EXEC);
            r_d.dab   = (acc_e'(r_q.acc) != ACC_EXEC);
        end
        if (end_ill) begin
            r_d.illegal = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy         = (r_q.st != WS_IDLE);
    assign mem_req      = r_q.mem_req;
    assign mem_addr     = r_q.mem_addr;
    assign done         = r_q.done;
    assign pa           = r_q.pa;
    assign big_page     = r_q.big;
    assign grant_rd     = r_q.rwx[2];
    assign grant_wr     = r_q.rwx[1];
    assign grant_ex     = r_q.rwx[0];
    assign fault        = r_q.fault;
    assign illegal      = r_q.illegal;
    assign iabort       = r_q.iab;
    assign dabort       = r_q.dab;
    assign fault_status = r_q.fsr;
    assign fault_addr   = r_q.far;
endmodule

// File: rtl/xw_walker_chk.sv
module xw_walker_chk #(
    parameter int AW = 32,
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [AW-1:0] req_va,
    input logic          req_user,
    input logic          mmu_on,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] pa,
    input logic          fault,
    input logic          illegal,
    input logic          iabort,
    input logic          dabort,
    input logic [CW-1:0] fault_status,
    input logic [AW-1:0] fault_addr
);
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    a_r10_busy_means_req: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> mem_req);

    a_r10_req_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r2_off_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && !mmu_on) |=> (done && !fault && !illegal && !busy));

    a_r3_priv_low_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && mmu_on && !req_user && !req_va[AW-1])
        |=> (done && !busy && pa == {1'b1, $past(req_va[AW-2:0])}));

    a_r7_illegal_not_fault: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !fault));

    a_r9_one_abort_kind: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($countones({iabort, dabort}) == 1));

    a_r9_no_abort_without_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> (!iabort && !dabort));

    a_r9_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> ($stable(fault_status) && $stable(fault_addr)));
endmodule

bind xw_walker xw_walker_chk #(.AW(AW), .CW(xw_pkg::CODE_W)) i_xw_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_va       (req_va),
    .req_user     (req_user),
    .mmu_on       (mmu_on),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_ack      (mem_ack),
    .busy         (busy),
    .done         (done),
    .pa           (pa),
    .fault        (fault),
    .illegal      (illegal),
    .iabort       (iabort),
    .dabort       (dabort),
    .fault_status (fault_status),
    .fault_addr   (fault_addr)
);

// File: tb/test_xw_walker.sv
`timescale 1ns/1ps
module test_xw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic        mmu_on = 1'b0;
    logic [31:0] tbl_base = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy, done, big_page, grant_rd, grant_wr, grant_ex;
    logic        fault, illegal, iabort, dabort;
    logic [31:0] pa, fault_addr;
    logic [4:0]  fault_status;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    xw_walker i_xw_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_acc(req_acc), .req_user(req_user), .mmu_on(mmu_on), .tbl_base(tbl_base),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .pa(pa), .big_page(big_page), .grant_rd(grant_rd),
        .grant_wr(grant_wr), .grant_ex(grant_ex), .fault(fault), .illegal(illegal),
        .iabort(iabort), .dabort(dabort), .fault_status(fault_status), .fault_addr(fault_addr)
    );

    // Table memory: every word is a hash of its address, biased towards useful types.
    function automatic logic [31:0] memf(input logic [31:0] a);
        logic [31:0] x;
        logic [1:0]  t;
        x = a ^ 32'h5bd1_e995;
        x = x * 32'h9E37_79B1;
        x = x ^ (x >> 15);
        x = x * 32'h85EB_CA6B;
        x = x ^ (x >> 13);
        case (x[27:25])
            3'd0, 3'd1, 3'd2: t = 2'd0;
            3'd3, 3'd4, 3'd5: t = 2'd3;
            3'd6:             t = 2'd1;
            default:          t = 2'd2;
        endcase
        return {x[31:3], (x[30:28] != 3'd0), t};
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference model state
    bit          m_busy = 0, m_done = 0;
    int          m_nrd = 0, m_rdi = 0;
    logic [31:0] m_a1, m_a2;
    logic [4:0]  m_fsr = '0;
    logic [31:0] m_far = '0;
    logic [31:0] e_pa, e_va;
    logic        e_big, e_r, e_w, e_x, e_fault, e_ill, e_iab;
    logic [4:0]  e_code;
    string       e_tag = "R1";

    task automatic model_accept(input logic [31:0] va, input logic [1:0] acc, input logic u,
                                input logic en, input logic [31:0] base);
        logic [31:0] d1, d2, dsel;
        e_va = va; e_fault = 0; e_ill = 0; e_big = 0; e_code = '0;
        e_r = 1; e_w = 1; e_x = 1; e_iab = (acc == 2'd2);
        m_nrd = 0; dsel = '0;
        m_a1 = (base & 32'hFFFF_F000) | ((va >> 20) & 32'hFFC);
        if (!en) begin
            e_pa = va; e_tag = "R2";
        end else if (!u && !va[31]) begin
            e_pa = va | 32'h8000_0000; e_tag = "R3";
        end else begin
            m_nrd = 1;
            d1 = memf(m_a1);
            if (d1[1:0] == 2'd3) begin
                if (!d1[2]) begin e_fault = 1; e_code = 5'h0B; e_tag = "R6"; end
                else begin e_pa = {d1[31:22], va[21:0]}; e_big = 1; dsel = d1; e_tag = "R4"; end
            end else if (d1[1:0] == 2'd0) begin
                if (!d1[2]) begin e_fault = 1; e_code = 5'h05; e_tag = "R6"; end
                else begin
                    m_nrd = 2;
                    m_a2 = (d1 & 32'hFFFF_F000) | ((va >> 10) & 32'hFFC);
                    d2 = memf(m_a2);
                    if (!d2[2]) begin e_fault = 1; e_code = 5'h08; e_tag = "R6"; end
                    else if (d2[1:0] != 2'd0) begin e_ill = 1; e_tag = "R7"; end
                    else begin e_pa = {d2[31:12], va[11:0]}; dsel = d2; e_tag = "R5"; end
                end
            end else begin
                e_ill = 1; e_tag = "R7";
            end
            if (!e_fault && !e_ill) begin
                e_r = dsel[8]; e_w = dsel[7]; e_x = dsel[6];
                if (u) begin
                    if (acc == 2'd0 && !e_r) begin e_fault = 1; e_code = 5'h11; e_tag = "R8"; end
                    if (acc == 2'd1 && !e_w) begin e_fault = 1; e_code = 5'h12; e_tag = "R8"; end
                    if (acc == 2'd2 && !e_x) begin e_fault = 1; e_code = 5'h13; e_tag = "R8"; end
                end
            end
        end
    endtask

    task automatic model_finish();
        m_done = 1;
        if (e_fault) begin m_fsr = e_code; m_far = e_va; end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_fsr = '0; m_far = '0; m_rdi = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (mem_ack) begin
                    m_rdi++;
                    if (m_rdi == m_nrd) begin m_busy = 0; model_finish(); end
                end
            end else if (req_valid) begin  // R11: accept only while idle
                model_accept(req_va, req_acc, req_user, mmu_on, tbl_base);
                m_rdi = 0;
                if (m_nrd == 0) model_finish();
                else m_busy = 1;
            end
        end
    end

    // Memory responder: 0..2 idle cycles before each acknowledge
    int rsp_cnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; rsp_cnt = 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0; rsp_cnt = $urandom % 3;
        end else if (mem_req) begin
            if (rsp_cnt == 0) begin mem_ack <= 1'b1; mem_rdata <= memf(mem_addr); end
            else rsp_cnt--;
        end
    end

    // Per-cycle comparison, then new stimulus
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R10", "busy", busy, m_busy);
            chk("R10", "mem_req", mem_req, m_busy);
            if (m_busy) chk(m_rdi == 0 ? "R4" : "R5", "mem_addr", mem_addr, m_rdi == 0 ? m_a1 : m_a2);
            chk("R11", "done", done, m_done);
            chk("R9", "fault_status", fault_status, m_fsr);
            chk("R9", "fault_addr", fault_addr, m_far);
            if (m_done) begin
                chk(e_tag, "fault", fault, e_fault);
                chk("R7", "illegal", illegal, e_ill);
                if (e_fault) begin
                    chk("R9", "iabort", iabort, e_iab);
                    chk("R9", "dabort", dabort, !e_iab);
                end
                if (!e_fault && !e_ill) begin
                    chk(e_tag, "pa", pa, e_pa);
                    chk(e_tag, "big_page", big_page, e_big);
                    chk("R8", "grants", {grant_rd, grant_wr, grant_ex}, {e_r, e_w, e_x});
                end
            end
            req_valid <= ($urandom % 4) != 0;
            req_va    <= $urandom;
            req_acc   <= 2'($urandom % 3);
            req_user  <= $urandom % 2;
            mmu_on    <= ($urandom % 6) != 0;
            tbl_base  <= $urandom;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, checked before any request can be accepted
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "mem_req", mem_req, 0);
        chk("R1", "fault_status", fault_status, 0);
        chk("R1", "fault_addr", fault_addr, 0);
        repeat (40000) @(posedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule